// File: doc/BRIEF.md
# Level Interrupt Cause and Mask Unit

This block gathers seven level-style interrupt sources into one combined interrupt line. A source that is high on a clock edge latches a 1 into its bit of the cause register. The bit then stays set until software writes over it. A mask register selects which latched causes are forwarded. The registered output `irq_out` is high whenever at least one cause bit is set and also enabled.

Software reaches both registers through a small 32-bit register port. The cause register sits at byte offset 0x50 and the mask register at 0x54. The cause register is plain read/write, not write-one-to-clear. Writing a 1 to a cause bit raises that interrupt, and writing a 0 clears it. Software picks the order in which it services pending sources, normally the highest set bit first. The hardware does no priority encoding.

An access is decoded into one of three register selections: none, cause or mask. Writes go to the selected register. Reads return the selected register and are combinational. There is no other sequencing.

Top module: `irqcm_unit`

## Requirements
- R1: While `rst_n` is low and after its release, the cause and mask registers are all zero and `irq_out` is low.
- R2: A write (`bus_sel`=1, `bus_we`=1) to offset 0x50 loads bits 6:0 of `bus_wdata` into the cause register. A 1 sets a cause bit and a 0 clears it. The new value is visible after that clock edge.
- R3: If `evt_in[i]` is high on a clock edge, cause bit i is 1 after that edge. This holds even when a cause write of 0 to bit i lands on the same edge. With no event and no cause write, a cause bit keeps its value.
- R4: A write to offset 0x54 loads bits 6:0 of `bus_wdata` into the mask register. A mask bit of 1 enables forwarding of its source and 0 blocks it.
- R5: `irq_out` is registered. On each clock edge it takes the value of (any bit of cause AND mask is 1) as it stood before that edge. It therefore rises one cycle after an enabled cause bit becomes set, and falls one cycle after the last enabled cause clears.
- R6: Bits 31:7 of both registers read as 0. Writes to those bit positions have no effect.
- R7: With `bus_sel`=1 and `bus_we`=0, `bus_rdata` shows the cause register at offset 0x50 and the mask register at 0x54 in the same cycle. It reads 0 for any other offset or when `bus_sel`=0. Writes to other offsets change neither register.
- R8: Writing 0 to the mask and then 0 to the cause, with no events present, leaves both registers zero and drives `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| evt_in | input | 7 | Level interrupt sources, bit i = source i |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
Register writes and source events take effect at the clock edge where they are sampled. Read data is combinational, so a register is checked by reading it in the cycle after the edge that changed it, before the next edge. `irq_out` is one register further on. The bench therefore updates its model at each edge from the pre-edge cause and mask values, and samples `irq_out` shortly after every edge. Random mixes of writes, reads and events are checked this way. Directed cases cover an event colliding with a clearing write, wide write data, unmapped offsets and full clearing.

// File: rtl/irqcm_pkg.sv
package irqcm_pkg;
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_MASK  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irqcm_decode.sv
module irqcm_decode
    import irqcm_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  CAUSE_OFS = 8'h50,
    parameter logic [7:0]  MASK_OFS  = 8'h54
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          hit
);
    localparam logic [ADDR_W-1:0] CAUSE_A = ADDR_W'(CAUSE_OFS);
    localparam logic [ADDR_W-1:0] MASK_A  = ADDR_W'(MASK_OFS);

    always_comb begin
        hit = SEL_NONE;
        if (bus_sel) begin
            if (bus_addr == CAUSE_A)     hit = SEL_CAUSE;
            else if (bus_addr == MASK_A) hit = SEL_MASK;
        end
    end
endmodule

// File: rtl/irqcm_cause_bank.sv
module irqcm_cause_bank #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] wr_bits,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic [NUM_SRC-1:0] cause_q
);
    // One latch cell per source; a live event overrides the software value.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cause_q[i] <= 1'b0;
            else if (evt_in[i]) cause_q[i] <= 1'b1;
            else if (wr_en)     cause_q[i] <= wr_bits[i];
        end
    end
endmodule

// File: rtl/irqcm_mask_reg.sv
module irqcm_mask_reg #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] wr_bits,
    output logic [NUM_SRC-1:0] mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wr_bits;
    end
endmodule

// File: rtl/irqcm_unit.sv
module irqcm_unit
    import irqcm_pkg::*;
#(
    parameter int          NUM_SRC   = 7,
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  CAUSE_OFS = 8'h50,
    parameter logic [7:0]  MASK_OFS  = 8'h54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic              irq_out
);
    reg_sel_e           hit;
    logic [NUM_SRC-1:0] cause_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               cause_wr;
    logic               mask_wr;
    logic               irq_q;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    irqcm_decode #(
        .ADDR_W    (ADDR_W),
        .CAUSE_OFS (CAUSE_OFS),
        .MASK_OFS  (MASK_OFS)
    ) u_decode (
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .hit      (hit)
    );

    assign cause_wr = bus_we && (hit == SEL_CAUSE);
    assign mask_wr  = bus_we && (hit == SEL_MASK);

    irqcm_cause_bank #(.NUM_SRC(NUM_SRC)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cause_wr),
        .wr_bits (bus_wdata[NUM_SRC-1:0]),
        .evt_in  (evt_in),
        .cause_q (cause_q)
    );

    irqcm_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr),
        .wr_bits (bus_wdata[NUM_SRC-1:0]),
        .mask_q  (mask_q)
    );

    // Read mux: unused upper bits are always zero.
    always_comb begin
        bus_rdata = '0;
        unique case (hit)
            SEL_CAUSE: bus_rdata[NUM_SRC-1:0] = cause_q;
            SEL_MASK:  bus_rdata[NUM_SRC-1:0] = mask_q;
            default:   bus_rdata = '0;
        endcase
    end

    // Registered combined interrupt.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(cause_q & mask_q);
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/irqcm_unit_chk.sv
module irqcm_unit_chk #(
    parameter int          NUM_SRC   = 7,
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  CAUSE_OFS = 8'h50,
    parameter logic [7:0]  MASK_OFS  = 8'h54
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] evt_in,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] cause_q,
    input logic [NUM_SRC-1:0] mask_q
);
    localparam logic [ADDR_W-1:0] CA = ADDR_W'(CAUSE_OFS);
    localparam logic [ADDR_W-1:0] MA = ADDR_W'(MASK_OFS);

    logic wr_c, wr_m, other;
    assign wr_c  = bus_sel && bus_we && (bus_addr == CA);
    assign wr_m  = bus_sel && bus_we && (bus_addr == MA);
    assign other = bus_sel && (bus_addr != CA) && (bus_addr != MA);

    p_cause_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c |=> cause_q == ($past(bus_wdata[NUM_SRC-1:0]) | $past(evt_in)));

    p_evt_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0) |=> ((cause_q & $past(evt_in)) == $past(evt_in)));

    p_cause_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_c && evt_in == '0) |=> $stable(cause_q));

    p_mask_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_m |=> mask_q == $past(bus_wdata[NUM_SRC-1:0]));

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_m |=> $stable(mask_q));

    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q & mask_q) != '0) |=> irq_out);

    p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_q & mask_q) == '0) |=> !irq_out);

    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_SRC] == '0);

    p_other_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (other || !bus_sel) |-> bus_rdata == '0);
endmodule

bind irqcm_unit irqcm_unit_chk #(
    .NUM_SRC   (NUM_SRC),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CAUSE_OFS (CAUSE_OFS),
    .MASK_OFS  (MASK_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_in    (evt_in),
    .irq_out   (irq_out),
    .cause_q   (cause_q),
    .mask_q    (mask_q)
);

// File: tb/irqcm_unit_bench.sv
`timescale 1ns/1ps
module irqcm_unit_bench;
    localparam int NS = 7;
    localparam logic [7:0] A_CAUSE = 8'h50;
    localparam logic [7:0] A_MASK  = 8'h54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NS-1:0] evt_in = '0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [NS-1:0] m_cause = '0;
    logic [NS-1:0] m_mask  = '0;
    logic          m_irq   = 1'b0;

    always #10 clk = ~clk;

    irqcm_unit u_irqcm_unit (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .irq_out(irq_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic sel, logic [7:0] a);
        if (!sel)         return 32'h0;
        if (a == A_CAUSE) return {25'h0, m_cause};
        if (a == A_MASK)  return {25'h0, m_mask};
        return 32'h0;
    endfunction

    // One cycle: drive at negedge, check read data before the edge,
    // update the model at the edge, check irq_out after it.
    task automatic step(logic sel, logic we, logic [7:0] a,
                        logic [31:0] wd, logic [NS-1:0] ev, string req);
        logic nxt_irq;
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd; evt_in = ev;
        #1;
        if (sel && !we) chk({req, " rdata"}, bus_rdata, exp_read(sel, a));
        @(posedge clk);
        nxt_irq = |(m_cause & m_mask);
        if (sel && we && a == A_CAUSE) m_cause = wd[NS-1:0];
        m_cause = m_cause | ev;
        if (sel && we && a == A_MASK) m_mask = wd[NS-1:0];
        m_irq = nxt_irq;
        #2;
        chk("R5 irq_out", {31'h0, irq_out}, {31'h0, m_irq});
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5eed);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq in reset", {31'h0, irq_out}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset values
        step(1, 0, A_CAUSE, 0, 0, "R1 cause after reset");
        step(1, 0, A_MASK, 0, 0, "R1 mask after reset");
        // R2/R4: set and read back
        step(1, 1, A_CAUSE, 32'h0000_0041, 0, "R2");
        step(1, 0, A_CAUSE, 0, 0, "R2 read cause");
        step(1, 1, A_MASK, 32'h0000_0040, 0, "R4");
        step(1, 0, A_MASK, 0, 0, "R4 read mask");
        step(0, 0, 0, 0, 0, "R5 rise");
        // R3: event collides with clearing write
        step(1, 1, A_CAUSE, 32'h0, 7'h04, "R3 collide");
        step(1, 0, A_CAUSE, 0, 0, "R3 read after collide");
        // R6: upper bits ignored
        step(1, 1, A_MASK, 32'hFFFF_FF80, 0, "R6 mask hi");
        step(1, 0, A_MASK, 0, 0, "R6 read mask");
        step(1, 1, A_CAUSE, 32'hFFFF_FFFF, 0, "R6 cause all");
        step(1, 0, A_CAUSE, 0, 0, "R6 read cause");
        // R7: other offset write ignored, read zero
        step(1, 1, 8'h58, 32'h0, 0, "R7 other write");
        step(1, 0, 8'h58, 0, 0, "R7 other read");
        step(1, 0, A_CAUSE, 0, 0, "R7 cause kept");
        // R8: clear everything
        step(1, 1, A_MASK, 0, 0, "R8 mask off");
        step(1, 1, A_CAUSE, 0, 0, "R8 cause off");
        step(1, 0, A_CAUSE, 0, 0, "R8 read cause");
        step(0, 0, 0, 0, 0, "R8 irq low");
        chk("R8 irq cleared", {31'h0, irq_out}, 32'h0);
        // Random mix
        for (int k = 0; k < 600; k++) begin
            int unsigned op;
            logic [NS-1:0] ev;
            logic [31:0] wd;
            op = $urandom % 8;
            wd = $urandom;
            ev = (($urandom % 4) == 0) ? NS'($urandom) : '0;
            unique case (op)
                0, 1, 2: step(1, 1, A_CAUSE, wd, ev, "R2/R3 rand");
                3:       step(1, 1, A_MASK, wd, ev, "R4 rand");
                4:       step(1, 0, A_CAUSE, 0, ev, "R3 rand read");
                5:       step(1, 0, A_MASK, 0, ev, "R4 rand read");
                6:       step(0, 0, 0, wd, ev, "R5 idle");
                default: step(1, $urandom % 2 == 1, 8'h40 + 8'($urandom % 16) * 8'd4 + 8'd32,
                              wd, ev, "R7 rand other");
            endcase
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule